// File: doc/BRIEF.md
# RAID-5 Stripe Mapper and Small-Write Parity Updater

This block sits between a logical block write port and five independent disk request channels that share one request bus. A write carries a logical unit number and one data word. The block finds the stripe row that holds the unit and the disk that holds it. It also finds the disk that carries the parity for that row. It then performs the four-step read-modify-write that keeps the rotating parity consistent, and pulses a completion flag when the sequence ends.

Parity rotates across the five disks. The parity column moves one disk toward index 0 on each successive stripe and returns to the highest disk every fifth stripe. Data units fill the remaining four columns in ascending disk order. A single physical request is outstanding at a time. Each request is held until the disk side acknowledges it, so disks of any latency can be attached.

Top module: `r5_small_write`

## Requirements
- R1: The stripe row is the logical unit number divided by 4, and it is presented on `dsk_row`. The parity disk is 4 − (row mod 5), so it is disk 4 in rows 0, 5 and 10, disk 3 in row 1, and disk 0 in row 4. `dsk_idx` carries the disk number in plain binary, 0 to 4.
- R2: Let u = unit mod 4. The data disk is u when u is less than the parity disk, and u+1 otherwise. For example, units 4, 5, 6 and 7 map to disks 0, 1, 2 and 4.
- R3: Each accepted write issues exactly four requests, in this order: read the data disk, read the parity disk, write the data disk, write the parity disk. `dsk_we` is 0 for reads and 1 for writes.
- R4: The data write carries the new word. The parity write carries old parity XOR old data XOR new word, where both old values are the words returned on `dsk_rdata` with the read acknowledges.
- R5: A request stays asserted, with disk index, row and direction unchanged, until the cycle in which `dsk_ack` is high. The next request starts only after that.
- R6: `wr_ready` is low from the cycle after a write is accepted until the sequence completes. A write offered while `wr_ready` is low is ignored and causes no disk request.
- R7: `done` is high for exactly one cycle, in the cycle after the parity write is acknowledged. `wr_ready` is high again in that same cycle.
- R8: After reset, `dsk_req` and `done` are low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_valid | input | 1 | Logical write offered |
| wr_ready | output | 1 | Block idle and able to take a write |
| wr_lba | input | LBA_W | Logical unit number |
| wr_data | input | DATA_W | New data word |
| dsk_req | output | 1 | Physical request active |
| dsk_we | output | 1 | 1 = write, 0 = read |
| dsk_idx | output | DISK_W | Target disk index |
| dsk_row | output | LBA_W | Stripe row on the target disk |
| dsk_wdata | output | DATA_W | Write data |
| dsk_ack | input | 1 | Disk side accepts or completes the current request |
| dsk_rdata | input | DATA_W | Read data, valid with `dsk_ack` on reads |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first request appears in the cycle after the accepting edge. Each later request appears in the cycle after the previous acknowledge, and `done` appears in the cycle after the parity write acknowledge. The bench's disk model samples the request bus on the falling edge. It raises the acknowledge after a programmable number of falling edges, 0 to 3, and compares each request against the queued expectation at that moment. On the falling edge that follows a parity-write acknowledge, the model checks that `done` and `wr_ready` are high, and it flags `done` on any other falling edge. The latency is varied so that the hold behaviour is exercised both when the acknowledge comes at once and when it is delayed.

// File: rtl/r5_pkg.sv
package r5_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_DAT = 3'd1,
    ST_RD_PAR = 3'd2,
    ST_WR_DAT = 3'd3,
    ST_WR_PAR = 3'd4
  } step_t;
endpackage

// File: rtl/r5_rst_sync.sv
module r5_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/r5_stripe_map.sv
module r5_stripe_map #(
  parameter int NUM_DISKS = 5,
  parameter int LBA_W     = 8,
  localparam int DISK_W   = $clog2(NUM_DISKS)
) (
  input  logic [LBA_W-1:0]  lba,
  output logic [LBA_W-1:0]  row,
  output logic [DISK_W-1:0] data_disk,
  output logic [DISK_W-1:0] par_disk
);
  localparam int UNITS = NUM_DISKS - 1;
  localparam logic [LBA_W-1:0]  UNITS_V = LBA_W'(UNITS);
  localparam logic [LBA_W-1:0]  NDISK_V = LBA_W'(NUM_DISKS);
  localparam logic [DISK_W-1:0] LAST_V  = DISK_W'(NUM_DISKS - 1);

  logic [DISK_W-1:0] unit_pos;
  logic [DISK_W-1:0] rot;

  always_comb begin
    row       = lba / UNITS_V;
    unit_pos  = DISK_W'(lba % UNITS_V);
    rot       = DISK_W'(row % NDISK_V);
    par_disk  = LAST_V - rot;
    data_disk = (unit_pos >= par_disk) ? unit_pos + DISK_W'(1) : unit_pos;
  end
endmodule

// File: rtl/r5_parity_acc.sv
module r5_parity_acc #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  input  logic              fold_en,
  input  logic [DATA_W-1:0] fold_val,
  output logic [DATA_W-1:0] acc
);
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              acc_en;

  always_comb begin
    acc_en = load_en | fold_en;
    acc_d  = load_en ? load_val : (acc_q ^ fold_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/r5_rmw_fsm.sv
module r5_rmw_fsm
  import r5_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  ack,
  output step_t step,
  output logic  fold_en,
  output logic  done
);
  step_t step_q, step_d;
  logic  done_q, done_d;

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_IDLE:   if (start) step_d = ST_RD_DAT;
      ST_RD_DAT: if (ack)   step_d = ST_RD_PAR;
      ST_RD_PAR: if (ack)   step_d = ST_WR_DAT;
      ST_WR_DAT: if (ack)   step_d = ST_WR_PAR;
      ST_WR_PAR: if (ack)   step_d = ST_IDLE;
      default:              step_d = ST_IDLE;
    endcase
    done_d  = (step_q == ST_WR_PAR) && ack;
    fold_en = ack && ((step_q == ST_RD_DAT) || (step_q == ST_RD_PAR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign step = step_q;
  assign done = done_q;
endmodule

// File: rtl/r5_small_write.sv
module r5_small_write
  import r5_pkg::*;
#(
  parameter int NUM_DISKS = 5,
  parameter int LBA_W     = 8,
  parameter int DATA_W    = 16,
  localparam int DISK_W   = $clog2(NUM_DISKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [LBA_W-1:0]  wr_lba,
  input  logic [DATA_W-1:0] wr_data,
  output logic              dsk_req,
  output logic              dsk_we,
  output logic [DISK_W-1:0] dsk_idx,
  output logic [LBA_W-1:0]  dsk_row,
  output logic [DATA_W-1:0] dsk_wdata,
  input  logic              dsk_ack,
  input  logic [DATA_W-1:0] dsk_rdata,
  output logic              done
);
  logic              srst_n;
  logic              accept;
  logic              fold_en;
  step_t             step;
  logic [LBA_W-1:0]  map_row;
  logic [DISK_W-1:0] map_data, map_par;
  logic [LBA_W-1:0]  row_q;
  logic [DISK_W-1:0] ddisk_q, pdisk_q;
  logic [DATA_W-1:0] ndata_q;
  logic [DATA_W-1:0] acc;
  logic              ack_g;

  r5_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  r5_stripe_map #(.NUM_DISKS(NUM_DISKS), .LBA_W(LBA_W)) u_map (
    .lba       (wr_lba),
    .row       (map_row),
    .data_disk (map_data),
    .par_disk  (map_par)
  );

  assign wr_ready = (step == ST_IDLE);
  assign accept   = wr_valid && wr_ready;
  assign ack_g    = dsk_ack && (step != ST_IDLE);

  r5_rmw_fsm u_fsm (
    .clk     (clk),
    .rst_n   (srst_n),
    .start   (accept),
    .ack     (ack_g),
    .step    (step),
    .fold_en (fold_en),
    .done    (done)
  );

  r5_parity_acc #(.DATA_W(DATA_W)) u_acc (
    .clk      (clk),
    .rst_n    (srst_n),
    .load_en  (accept),
    .load_val (wr_data),
    .fold_en  (fold_en),
    .fold_val (dsk_rdata),
    .acc      (acc)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      row_q   <= '0;
      ddisk_q <= '0;
      pdisk_q <= '0;
      ndata_q <= '0;
    end else if (accept) begin
      row_q   <= map_row;
      ddisk_q <= map_data;
      pdisk_q <= map_par;
      ndata_q <= wr_data;
    end
  end

  always_comb begin
    dsk_req   = (step != ST_IDLE);
    dsk_we    = (step == ST_WR_DAT) || (step == ST_WR_PAR);
    dsk_idx   = ((step == ST_RD_DAT) || (step == ST_WR_DAT)) ? ddisk_q : pdisk_q;
    dsk_row   = row_q;
    dsk_wdata = (step == ST_WR_DAT) ? ndata_q : acc;
  end
endmodule

// File: rtl/r5_small_write_chk.sv
module r5_small_write_chk #(
  parameter int NUM_DISKS = 5,
  parameter int LBA_W     = 8,
  parameter int DATA_W    = 16,
  localparam int DISK_W   = $clog2(NUM_DISKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [LBA_W-1:0]  wr_lba,
  input logic [DATA_W-1:0] wr_data,
  input logic              dsk_req,
  input logic              dsk_we,
  input logic [DISK_W-1:0] dsk_idx,
  input logic [LBA_W-1:0]  dsk_row,
  input logic [DATA_W-1:0] dsk_wdata,
  input logic              dsk_ack,
  input logic [DATA_W-1:0] dsk_rdata,
  input logic              done
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsk_req && !dsk_ack) |=> (dsk_req && $stable(dsk_idx) && $stable(dsk_row) && $stable(dsk_we)));

  // R6
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_req |-> !wr_ready);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_pwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(dsk_req && dsk_ack && dsk_we));

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_req |-> (dsk_idx < DISK_W'(NUM_DISKS)));

  // R3
  read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (dsk_req && !dsk_we));
endmodule

bind r5_small_write r5_small_write_chk #(
  .NUM_DISKS(NUM_DISKS), .LBA_W(LBA_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/r5_small_write_tb.sv
module r5_small_write_tb;
  localparam int LBA_W  = 8;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [2:0]        d;
    logic [LBA_W-1:0]  r;
    logic              we;
    logic [DATA_W-1:0] w;
    logic              last;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [LBA_W-1:0] wr_lba = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic dsk_req, dsk_we, done;
  logic [2:0] dsk_idx;
  logic [LBA_W-1:0] dsk_row;
  logic [DATA_W-1:0] dsk_wdata;
  logic dsk_ack = 1'b0;
  logic [DATA_W-1:0] dsk_rdata = '0;

  int errors = 0;
  int checks = 0;
  int lat = 0;
  int wait_cnt = 0;
  int done_seen = 0;
  int writes = 0;
  int cycles = 0;
  bit pend_done = 0;
  exp_t expq[$];
  logic [DATA_W-1:0] mem  [0:4][0:255];
  logic [DATA_W-1:0] gold [0:4][0:255];

  always #2.5 clk = ~clk;

  r5_small_write u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_lba(wr_lba), .wr_data(wr_data), .dsk_req(dsk_req), .dsk_we(dsk_we),
    .dsk_idx(dsk_idx), .dsk_row(dsk_row), .dsk_wdata(dsk_wdata),
    .dsk_ack(dsk_ack), .dsk_rdata(dsk_rdata), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // driver: computes expected requests from the requirements and pushes them
  task automatic do_write(input logic [LBA_W-1:0] lba, input logic [DATA_W-1:0] dat);
    int row, pd, u, dd;
    logic [DATA_W-1:0] np;
    exp_t e;
    row = int'(lba) / 4;                 // R1
    pd  = 4 - (row % 5);                 // R1
    u   = int'(lba) % 4;
    dd  = (u >= pd) ? u + 1 : u;         // R2
    np  = gold[pd][row] ^ gold[dd][row] ^ dat;   // R4
    e = '{d: 3'(dd), r: 8'(row), we: 1'b0, w: '0, last: 1'b0}; expq.push_back(e);
    e = '{d: 3'(pd), r: 8'(row), we: 1'b0, w: '0, last: 1'b0}; expq.push_back(e);
    e = '{d: 3'(dd), r: 8'(row), we: 1'b1, w: dat, last: 1'b0}; expq.push_back(e);
    e = '{d: 3'(pd), r: 8'(row), we: 1'b1, w: np, last: 1'b1}; expq.push_back(e);
    gold[dd][row] = dat;
    gold[pd][row] = np;
    writes++;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_lba = lba; wr_data = dat;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0 || !wr_ready || pend_done) @(negedge clk);
  endtask

  // disk model and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_done) begin
        chk(done == 1'b1, "R7", "done after parity write", int'(done), 1);
        chk(wr_ready == 1'b1, "R7", "ready with done", int'(wr_ready), 1);
        if (done) done_seen++;
        pend_done = 0;
      end else if (done) begin
        chk(1'b0, "R7", "unexpected done", 1, 0);
      end
      if (dsk_ack) begin
        dsk_ack = 1'b0;
        wait_cnt = 0;
      end else if (dsk_req) begin
        if (wait_cnt >= lat) begin
          exp_t e;
          if (expq.size() == 0) begin
            chk(1'b0, "R6", "request with nothing expected", int'(dsk_idx), 0);
          end else begin
            e = expq.pop_front();
            chk(dsk_idx == e.d, "R2", "disk index", int'(dsk_idx), int'(e.d));
            chk(dsk_row == e.r, "R1", "stripe row", int'(dsk_row), int'(e.r));
            chk(dsk_we == e.we, "R3", "step direction", int'(dsk_we), int'(e.we));
            if (e.we) chk(dsk_wdata == e.w, "R4", "write data", int'(dsk_wdata), int'(e.w));
            if (e.last) pend_done = 1;
          end
          if (dsk_we) mem[dsk_idx][dsk_row] = dsk_wdata;
          else        dsk_rdata = mem[dsk_idx][dsk_row];
          dsk_ack = 1'b1;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 5; d++)
      for (int r = 0; r < 256; r++) begin
        mem[d][r]  = 16'(d * 4099 + r * 257 + 3);
        gold[d][r] = 16'(d * 4099 + r * 257 + 3);
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk(dsk_req == 1'b0, "R8", "req after reset", int'(dsk_req), 0);
    chk(wr_ready == 1'b1, "R8", "ready after reset", int'(wr_ready), 1);
    chk(done == 1'b0, "R8", "done after reset", int'(done), 0);

    // R1 R2: stripe 0, parity on disk 4, immediate ack
    lat = 0;
    for (int i = 0; i < 4; i++) do_write(8'(i), 16'(16'h1000 + i));
    drain();
    // stripe 1, parity on disk 3, one-cycle latency (R5)
    lat = 1;
    for (int i = 4; i < 8; i++) do_write(8'(i), 16'(16'h2200 + i));
    drain();
    // stripe 4 (parity disk 0), stripe 5 (parity back on 4), top unit
    lat = 3;
    do_write(8'd16, 16'hBEEF);
    do_write(8'd19, 16'h0F0F);
    do_write(8'd20, 16'h1234);
    do_write(8'd255, 16'hA5A5);
    drain();
    // R4: repeated writes to one unit chain the parity
    lat = 2;
    do_write(8'd5, 16'h5555);
    do_write(8'd5, 16'hAAAA);
    drain();
    // R6: offer a write while busy, it must be refused
    do_write(8'd9, 16'h7777);
    wr_valid = 1'b1; wr_lba = 8'd13; wr_data = 16'hDEAD;
    chk(wr_ready == 1'b0, "R6", "ready while busy", int'(wr_ready), 0);
    @(negedge clk);
    chk(wr_ready == 1'b0, "R6", "ready while busy", int'(wr_ready), 0);
    wr_valid = 1'b0;
    drain();
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R6", "leftover expectations", expq.size(), 0);
    chk(gold[1][3] == mem[1][3], "R6", "refused write left disk 1 row 3", int'(mem[1][3]), int'(gold[1][3]));
    chk(done_seen == writes, "R7", "done pulse count", done_seen, writes);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule